// File: doc/BRIEF.md
# IDE Controller Configuration Register Window

This block serves the device-specific part of an IDE controller's PCI configuration space. A configuration request carries a byte offset, an access size in bytes, a write flag and write data. Offsets under the device-specific boundary (0x40) belong to the standard configuration header. They are handed on unchanged to a separate header port, and the header's read data comes back through this block.

Offsets inside a 22-byte window that begins at 0x40 are held in local byte registers. Reads and writes of 1, 2 or 4 bytes are accepted, and multi-byte data is little-endian. An access that would cross the end of the window, starts past it, or uses any other size gets an error flag in the same cycle as the request and changes nothing.

Inside the window sit these fields:
- a 32-bit primary channel timing word, which resets to a value that enables both channels;
- an 8-bit secondary timing byte;
- an 8-bit Ultra DMA control byte;
- a 16-bit Ultra DMA timing word;
- a 16-bit controller configuration word;
- reserved bytes between them, which store what is written to them.

The fields are also driven out as decoded ports for the rest of the controller. Reads return data at once, in the request cycle. Writes take effect on the next clock edge.

Top module: `ide_cfg_window`

## Requirements
- R1: A request with offset below 0x40 asserts hdr_req in the same cycle, with hdr_off, hdr_size, hdr_wdata and hdr_wr equal to the request's. cfg_rdata equals hdr_rdata, cfg_err stays low and no window byte changes.
- R2: A request is served locally when cfg_size is 1, 2 or 4, cfg_off is at least 0x40, and cfg_off plus cfg_size is at most 0x56. Such a request raises neither cfg_err nor hdr_req.
- R3: Any other request with offset at or above 0x40 raises cfg_err in the same cycle. Examples are size 0, 3, 5, 6 or 7, a span past 0x55, or an offset past 0x55. Such a request drives cfg_rdata to zero and leaves every window byte unchanged, even when it is a write.
- R4: After reset, window bytes 0 to 3 hold 0x00, 0x80, 0x00, 0x80, so the dword at 0x40 reads 0x80008000. Every other window byte holds zero.
- R5: A local read returns window byte (cfg_off-0x40+j) in cfg_rdata bits [8j+7:8j] for each j below cfg_size. Bits above the access size are zero.
- R6: A local write replaces only window bytes cfg_off-0x40 up to cfg_off-0x40+cfg_size-1. The lowest of them takes cfg_wdata[7:0], and each following byte takes the next byte lane up. All other bytes keep their value.
- R7: The field ports are assembled little-endian from the window bytes:
  - prim_tim from bytes 0 to 3;
  - sec_tim from byte 4;
  - udma_ctl from byte 8;
  - udma_tim from bytes 10 and 11;
  - ide_cfg from bytes 20 and 21.
- R8: cfg_err and hdr_req are high only in a cycle where cfg_req is high. cfg_err lasts exactly as long as the offending request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_req | input | 1 | Configuration access request |
| cfg_wr | input | 1 | 1 = write, 0 = read |
| cfg_off | input | 8 | Configuration byte offset |
| cfg_size | input | 3 | Access size in bytes |
| cfg_wdata | input | 32 | Write data, lowest byte lane first |
| cfg_rdata | output | 32 | Read data, same cycle as the request |
| cfg_err | output | 1 | Illegal size or address |
| hdr_req | output | 1 | Request routed to header logic |
| hdr_wr | output | 1 | Write flag to header logic |
| hdr_off | output | 8 | Offset to header logic |
| hdr_size | output | 3 | Size to header logic |
| hdr_wdata | output | 32 | Write data to header logic |
| hdr_rdata | input | 32 | Read data from header logic |
| prim_tim | output | 32 | Primary channel timing field |
| sec_tim | output | 8 | Secondary timing field |
| udma_ctl | output | 8 | Ultra DMA control field |
| udma_tim | output | 16 | Ultra DMA timing field |
| ide_cfg | output | 16 | Controller configuration field |

## Verification
The bench sweeps every offset from 0 to 255 against every size from 0 to 7. It checks routing, the error flag and the read data against a byte-array model. This catches an off-by-one at the window end: a design with that fault would wrongly accept or refuse dword and word accesses at 0x53 to 0x55. It also catches a missing size filter, which would let 3-byte accesses through.

Writes are made at every legal offset and size, and all field ports are compared after each one. A byte-enable or lane-alignment fault shows up as a neighbouring field being overwritten, or as data shifted into the wrong byte. Illegal and header-routed writes are followed by field checks, which expose any design that still writes local storage when it should not. The reset image is read back byte by byte, which catches a timing word stored in the wrong byte order.

// File: rtl/ide_cfg_pkg.sv
package ide_cfg_pkg;

   localparam int unsigned BYTE_W    = 8;
   localparam int unsigned BUS_BYTES = 4;
   localparam int unsigned BUS_W     = BUS_BYTES * BYTE_W;
   localparam int unsigned LANE_W    = $clog2(BUS_BYTES);
   localparam int unsigned SIZE_W    = 3;

   // field byte positions inside the window (decoded by the controller)
   localparam int unsigned PRIM_TIM_POS = 0;
   localparam int unsigned SEC_TIM_POS  = 4;
   localparam int unsigned UDMA_CTL_POS = 8;
   localparam int unsigned UDMA_TIM_POS = 10;
   localparam int unsigned IDE_CFG_POS  = 20;

   typedef enum logic [1:0] {
      ROUTE_NONE  = 2'd0,
      ROUTE_HDR   = 2'd1,
      ROUTE_LOCAL = 2'd2,
      ROUTE_ERR   = 2'd3
   } route_e;

   function automatic logic size_ok(input logic [SIZE_W-1:0] sz);
      return (sz == 3'd1) || (sz == 3'd2) || (sz == 3'd4);
   endfunction

endpackage

// File: rtl/ide_cfg_decode.sv
module ide_cfg_decode
   import ide_cfg_pkg::*;
#(
   parameter int unsigned OFF_W     = 8,
   parameter int unsigned HDR_LIMIT = 64,
   parameter int unsigned WIN_BASE  = 64,
   parameter int unsigned WIN_BYTES = 22,
   localparam int unsigned IDX_W    = $clog2(WIN_BYTES)
) (
   input  logic                 req,
   input  logic [OFF_W-1:0]     off,
   input  logic [SIZE_W-1:0]    size,
   output route_e               route,
   output logic [IDX_W-1:0]     idx,
   output logic [WIN_BYTES-1:0] byte_en
);

   localparam logic [OFF_W:0] BASE_X = (OFF_W+1)'(WIN_BASE);
   localparam logic [OFF_W:0] END_X  = (OFF_W+1)'(WIN_BASE + WIN_BYTES);
   localparam logic [OFF_W:0] HDR_X  = (OFF_W+1)'(HDR_LIMIT);

   logic [OFF_W:0] off_x;
   logic [OFF_W:0] end_x;
   logic           in_win;

   assign off_x  = {1'b0, off};
   assign end_x  = off_x + (OFF_W+1)'(size);
   assign in_win = (off_x >= BASE_X) && (end_x <= END_X);
   assign idx    = IDX_W'(off - OFF_W'(WIN_BASE));

   always_comb begin
      if (!req)
         route = ROUTE_NONE;
      else if (off_x < HDR_X)
         route = ROUTE_HDR;
      else if (size_ok(size) && in_win)
         route = ROUTE_LOCAL;
      else
         route = ROUTE_ERR;
   end

   // one enable per window byte: inside [idx, idx+size)
   for (genvar i = 0; i < WIN_BYTES; i++) begin : g_en
      logic [IDX_W:0] pos;
      logic [IDX_W:0] lim;
      assign pos        = (IDX_W+1)'(i);
      assign lim        = {1'b0, idx} + (IDX_W+1)'(size);
      assign byte_en[i] = (route == ROUTE_LOCAL) &&
                          (pos >= {1'b0, idx}) && (pos < lim);
   end

endmodule

// File: rtl/ide_cfg_store.sv
module ide_cfg_store
   import ide_cfg_pkg::*;
#(
   parameter int unsigned               WIN_BYTES = 22,
   parameter logic [WIN_BYTES*8-1:0]    RST_IMG   = '0,
   localparam int unsigned              IDX_W     = $clog2(WIN_BYTES)
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              wr_en,
   input  logic [WIN_BYTES-1:0]              byte_en,
   input  logic [IDX_W-1:0]                  idx,
   input  logic [BUS_W-1:0]                  wdata,
   output logic [WIN_BYTES-1:0][BYTE_W-1:0]  bytes_q
);

   for (genvar i = 0; i < WIN_BYTES; i++) begin : g_byte
      logic [LANE_W-1:0] lane;
      assign lane = LANE_W'(IDX_W'(i) - idx);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            bytes_q[i] <= RST_IMG[i*BYTE_W +: BYTE_W];
         else if (wr_en && byte_en[i])
            bytes_q[i] <= wdata[{lane, 3'b000} +: BYTE_W];
      end
   end

endmodule

// File: rtl/ide_cfg_rdmux.sv
module ide_cfg_rdmux
   import ide_cfg_pkg::*;
#(
   parameter int unsigned  WIN_BYTES = 22,
   localparam int unsigned IDX_W     = $clog2(WIN_BYTES)
) (
   input  route_e                            route,
   input  logic [IDX_W-1:0]                  idx,
   input  logic [SIZE_W-1:0]                 size,
   input  logic [WIN_BYTES-1:0][BYTE_W-1:0]  bytes_q,
   input  logic [BUS_W-1:0]                  hdr_rdata,
   output logic [BUS_W-1:0]                  rdata
);

   logic [BUS_W-1:0] loc;

   always_comb begin
      loc = '0;
      for (int j = 0; j < int'(BUS_BYTES); j++) begin
         if (j < int'(size) && (int'(idx) + j) < int'(WIN_BYTES))
            loc[j*BYTE_W +: BYTE_W] = bytes_q[int'(idx) + j];
      end
   end

   always_comb begin
      case (route)
         ROUTE_HDR:   rdata = hdr_rdata;
         ROUTE_LOCAL: rdata = loc;
         default:     rdata = '0;
      endcase
   end

endmodule

// File: rtl/ide_cfg_window.sv
module ide_cfg_window
   import ide_cfg_pkg::*;
#(
   parameter int unsigned  OFF_W        = 8,
   parameter int unsigned  HDR_LIMIT    = 64,
   parameter int unsigned  WIN_BASE     = 64,
   parameter int unsigned  WIN_BYTES    = 22,
   parameter logic [31:0]  PRIM_TIM_RST = 32'h8000_8000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_req,
   input  logic              cfg_wr,
   input  logic [OFF_W-1:0]  cfg_off,
   input  logic [2:0]        cfg_size,
   input  logic [31:0]       cfg_wdata,
   output logic [31:0]       cfg_rdata,
   output logic              cfg_err,
   output logic              hdr_req,
   output logic              hdr_wr,
   output logic [OFF_W-1:0]  hdr_off,
   output logic [2:0]        hdr_size,
   output logic [31:0]       hdr_wdata,
   input  logic [31:0]       hdr_rdata,
   output logic [31:0]       prim_tim,
   output logic [7:0]        sec_tim,
   output logic [7:0]        udma_ctl,
   output logic [15:0]       udma_tim,
   output logic [15:0]       ide_cfg
);

   localparam int unsigned IDX_W = $clog2(WIN_BYTES);

   // elaboration-time parameter checks
   if (WIN_BYTES < IDE_CFG_POS + 2) begin : g_bad_size
      $error("window too small for its fields");
   end
   if (HDR_LIMIT > WIN_BASE) begin : g_bad_limit
      $error("header range overlaps the window");
   end
   if (WIN_BASE + WIN_BYTES > (1 << OFF_W)) begin : g_bad_off
      $error("window exceeds offset space");
   end

   function automatic logic [WIN_BYTES*8-1:0] build_rst_img();
      logic [WIN_BYTES*8-1:0] img;
      img = '0;
      img[PRIM_TIM_POS*8 +: 32] = PRIM_TIM_RST;
      return img;
   endfunction

   localparam logic [WIN_BYTES*8-1:0] RST_IMG = build_rst_img();

   route_e                            route;
   logic [IDX_W-1:0]                  idx;
   logic [WIN_BYTES-1:0]              byte_en;
   logic [WIN_BYTES-1:0][BYTE_W-1:0]  bytes_q;

   ide_cfg_decode #(
      .OFF_W     (OFF_W),
      .HDR_LIMIT (HDR_LIMIT),
      .WIN_BASE  (WIN_BASE),
      .WIN_BYTES (WIN_BYTES)
   ) u_dec (
      .req     (cfg_req),
      .off     (cfg_off),
      .size    (cfg_size),
      .route   (route),
      .idx     (idx),
      .byte_en (byte_en)
   );

   ide_cfg_store #(
      .WIN_BYTES (WIN_BYTES),
      .RST_IMG   (RST_IMG)
   ) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (cfg_wr),
      .byte_en (byte_en),
      .idx     (idx),
      .wdata   (cfg_wdata),
      .bytes_q (bytes_q)
   );

   ide_cfg_rdmux #(
      .WIN_BYTES (WIN_BYTES)
   ) u_rd (
      .route     (route),
      .idx       (idx),
      .size      (cfg_size),
      .bytes_q   (bytes_q),
      .hdr_rdata (hdr_rdata),
      .rdata     (cfg_rdata)
   );

   assign cfg_err   = (route == ROUTE_ERR);
   assign hdr_req   = (route == ROUTE_HDR);
   assign hdr_wr    = cfg_wr & hdr_req;
   assign hdr_off   = cfg_off;
   assign hdr_size  = cfg_size;
   assign hdr_wdata = cfg_wdata;

   assign prim_tim = {bytes_q[PRIM_TIM_POS+3], bytes_q[PRIM_TIM_POS+2],
                      bytes_q[PRIM_TIM_POS+1], bytes_q[PRIM_TIM_POS]};
   assign sec_tim  = bytes_q[SEC_TIM_POS];
   assign udma_ctl = bytes_q[UDMA_CTL_POS];
   assign udma_tim = {bytes_q[UDMA_TIM_POS+1], bytes_q[UDMA_TIM_POS]};
   assign ide_cfg  = {bytes_q[IDE_CFG_POS+1], bytes_q[IDE_CFG_POS]};

endmodule

// File: rtl/ide_cfg_window_chk.sv
module ide_cfg_window_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        cfg_req,
   input logic [7:0]  cfg_off,
   input logic [2:0]  cfg_size,
   input logic [31:0] cfg_rdata,
   input logic        cfg_err,
   input logic        hdr_req,
   input logic [31:0] prim_tim,
   input logic [7:0]  sec_tim,
   input logic [7:0]  udma_ctl,
   input logic [15:0] udma_tim,
   input logic [15:0] ide_cfg
);

   logic [79:0] fields;
   assign fields = {prim_tim, sec_tim, udma_ctl, udma_tim, ide_cfg};

   p_hdr_no_err_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_req && hdr_req) |-> !cfg_err);

   p_hdr_no_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_req && hdr_req) |=> $stable(fields));

   p_win_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_req && cfg_off >= 8'h40 && cfg_off <= 8'h55 && cfg_size == 3'd1)
      |-> (!cfg_err && !hdr_req));

   p_err_no_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_req && cfg_err) |=> $stable(fields));

   p_err_zero_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |-> (cfg_rdata == 32'h0));

   p_reset_value_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (prim_tim == 32'h8000_8000 && sec_tim == 8'h0 &&
                        udma_ctl == 8'h0 && udma_tim == 16'h0 && ide_cfg == 16'h0));

   p_byte_upper_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_req && !hdr_req && cfg_size == 3'd1) |-> (cfg_rdata[31:8] == 24'h0));

   p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_req |-> (!cfg_err && !hdr_req));

endmodule

bind ide_cfg_window ide_cfg_window_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cfg_req   (cfg_req),
   .cfg_off   (cfg_off),
   .cfg_size  (cfg_size),
   .cfg_rdata (cfg_rdata),
   .cfg_err   (cfg_err),
   .hdr_req   (hdr_req),
   .prim_tim  (prim_tim),
   .sec_tim   (sec_tim),
   .udma_ctl  (udma_ctl),
   .udma_tim  (udma_tim),
   .ide_cfg   (ide_cfg)
);

// File: tb/ide_cfg_window_tb.sv
module ide_cfg_window_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_req = 1'b0;
   logic        cfg_wr = 1'b0;
   logic [7:0]  cfg_off = '0;
   logic [2:0]  cfg_size = '0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic        cfg_err;
   logic        hdr_req;
   logic        hdr_wr;
   logic [7:0]  hdr_off;
   logic [2:0]  hdr_size;
   logic [31:0] hdr_wdata;
   logic [31:0] hdr_rdata;
   logic [31:0] prim_tim;
   logic [7:0]  sec_tim;
   logic [7:0]  udma_ctl;
   logic [15:0] udma_tim;
   logic [15:0] ide_cfg;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;
   logic [7:0] mdl [22];

   always #2 clk = ~clk;

   // header stand-in: data derived from the forwarded request
   assign hdr_rdata = {hdr_off, ~hdr_off, 5'b0, hdr_size, 8'h5A};

   ide_cfg_window u_dut (
      .clk, .rst_n, .cfg_req, .cfg_wr, .cfg_off, .cfg_size, .cfg_wdata,
      .cfg_rdata, .cfg_err, .hdr_req, .hdr_wr, .hdr_off, .hdr_size,
      .hdr_wdata, .hdr_rdata, .prim_tim, .sec_tim, .udma_ctl, .udma_tim,
      .ide_cfg
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic bit legal(input int off, input int sz);
      return (sz == 1 || sz == 2 || sz == 4) && off >= 64 && off + sz <= 86;
   endfunction

   function automatic logic [31:0] mdl_read(input int off, input int sz);
      logic [31:0] v = '0;
      for (int j = 0; j < sz; j++) v[j*8 +: 8] = mdl[off - 64 + j];
      return v;
   endfunction

   task automatic chk_fields(input string req);
      chk({req, " prim_tim"}, prim_tim, {mdl[3], mdl[2], mdl[1], mdl[0]});
      chk({req, " sec_tim"},  {24'h0, sec_tim},  {24'h0, mdl[4]});
      chk({req, " udma_ctl"}, {24'h0, udma_ctl}, {24'h0, mdl[8]});
      chk({req, " udma_tim"}, {16'h0, udma_tim}, {16'h0, mdl[11], mdl[10]});
      chk({req, " ide_cfg"},  {16'h0, ide_cfg},  {16'h0, mdl[21], mdl[20]});
   endtask

   // drive one access; sample combinational result 1 ns later; commit at posedge
   task automatic access(input bit wr, input int off, input int sz,
                         input logic [31:0] wd, input string tag);
      bit lg;
      @(negedge clk);
      cfg_req = 1'b1; cfg_wr = wr; cfg_off = 8'(off); cfg_size = 3'(sz); cfg_wdata = wd;
      #1;
      lg = legal(off, sz);
      if (off < 64) begin
         chk({tag, " R1 hdr_req"}, {31'h0, hdr_req}, 32'h1);
         chk({tag, " R1 err"}, {31'h0, cfg_err}, 32'h0);
         chk({tag, " R1 rdata"}, cfg_rdata, {8'(off), ~8'(off), 5'b0, 3'(sz), 8'h5A});
         chk({tag, " R1 fwd"}, {hdr_off, 5'b0, hdr_size, 15'h0, hdr_wr}, {8'(off), 5'b0, 3'(sz), 15'h0, wr});
         chk({tag, " R1 wdata"}, hdr_wdata, wd);
      end else if (lg) begin
         chk({tag, " R2 err/hdr"}, {30'h0, cfg_err, hdr_req}, 32'h0);
         chk({tag, " R5 rdata"}, cfg_rdata, mdl_read(off, sz));
      end else begin
         chk({tag, " R3 err"}, {30'h0, cfg_err, hdr_req}, 32'h2);
         chk({tag, " R3 rdata"}, cfg_rdata, 32'h0);
      end
      @(posedge clk);
      if (wr && off >= 64 && lg)
         for (int j = 0; j < sz; j++) mdl[off - 64 + j] = wd[j*8 +: 8];
      #1;
      cfg_req = 1'b0;
      #1;
      chk({tag, " R8 idle"}, {30'h0, cfg_err, hdr_req}, 32'h0);
   endtask

   initial begin
      for (int i = 0; i < 22; i++) mdl[i] = 8'h00;
      mdl[1] = 8'h80; mdl[3] = 8'h80;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R4 reset image
      #1;
      chk_fields("R4 reset");
      access(1'b0, 64, 4, 32'h0, "R4 dword");
      chk("R4 dword 0x40", mdl_read(64, 4), 32'h8000_8000);
      for (int b = 0; b < 22; b++) access(1'b0, 64 + b, 1, 32'h0, "R4 byte");

      // R1/R2/R3/R5 read sweep over every offset and size
      for (int off = 0; off < 256; off++)
         for (int sz = 0; sz < 8; sz++)
            access(1'b0, off, sz, 32'hDEAD_BEEF, "sweep");

      // R6/R7 write every legal position, check fields after each
      for (int sz = 1; sz <= 4; sz = sz * 2)
         for (int off = 64; off + sz <= 86; off++) begin
            access(1'b1, off, sz, {8'(off), 8'(sz), 8'(off ^ 8'hA5), 8'(off + sz)}, "R6 write");
            chk_fields("R6 R7 after write");
         end

      // R3 illegal writes change nothing
      access(1'b1, 65, 3, 32'hFFFF_FFFF, "R3 size3 wr");
      access(1'b1, 84, 4, 32'hFFFF_FFFF, "R3 span wr");
      access(1'b1, 86, 1, 32'hFFFF_FFFF, "R3 past wr");
      access(1'b1, 64, 0, 32'hFFFF_FFFF, "R3 size0 wr");
      chk_fields("R3 after illegal writes");

      // R1 header writes change nothing locally
      access(1'b1, 16, 4, 32'h1234_5678, "R1 hdr wr");
      access(1'b1, 63, 2, 32'h1234_5678, "R1 hdr edge wr");
      chk_fields("R1 after hdr writes");

      // R7 field targeted writes, then full read-back
      access(1'b1, 64, 4, 32'hA1B2_C3D4, "R7 prim");
      access(1'b1, 68, 1, 32'h0000_0077, "R7 sec");
      access(1'b1, 72, 1, 32'h0000_0033, "R7 uctl");
      access(1'b1, 74, 2, 32'h0000_BEEF, "R7 utim");
      access(1'b1, 84, 2, 32'h0000_CAFE, "R7 icfg");
      chk("R7 prim_tim", prim_tim, 32'hA1B2_C3D4);
      chk("R7 udma_tim", {16'h0, udma_tim}, 32'h0000_BEEF);
      chk("R7 ide_cfg", {16'h0, ide_cfg}, 32'h0000_CAFE);
      chk_fields("R7 fields");
      for (int off = 64; off < 86; off++) access(1'b0, off, 1, 32'h0, "R5 readback");
      access(1'b0, 74, 2, 32'h0, "R5 word");

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule